// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block sits between a CPU data-memory port and an external parallel bus. The bus has an 8-bit line group that carries the low address byte and then the data byte. It also has a group of high-address pins whose driven width can be configured, and three control lines: an address latch enable and active-low read and write strobes. Each request is classified by its address. An address above the internal-memory top is external; any other address is internal. An external access runs a bus cycle: one cycle with the latch enable high and the low address on the shared lines, followed by 1 + W strobe cycles, where W is a wait count of 0 to 3. The controller stretches the CPU access by keeping `req_ready` low until the last strobe cycle.

The external address space can be divided into a lower sector and an upper sector. Each sector has its own wait count. While the interface is enabled it owns its pins. Internal accesses still show the address and pulse the latch enable, but the strobes stay idle. When the interface is disabled, every pin passes through the plain port values, and every access completes at once without mapping. An optional bus keeper holds the last driven byte on the shared lines while the controller is not driving them.

The CPU side follows valid/ready rules. While `req_valid` is high and `req_ready` is low, the CPU must hold `req_addr`, `req_we` and `req_wdata` stable. The transfer completes on the clock edge where both signals are high. Read data on `rd_data` is valid in that cycle. The configuration inputs are plain levels, and they are expected to stay stable while an access is in flight.

Top module: `xbus_ctrl`

## Requirements
- R1: With `cfg_en`=1, an address greater than `INT_TOP` is external. Any other address is internal, and an internal request is accepted in the cycle it is presented (`req_ready`=1 in that cycle).
- R2: An external request with wait count W holds `req_ready` low for W+1 cycles and is accepted in cycle W+2, counting the presenting cycle as the first.
- R3: The upper sector is selected when `cfg_sect`≠0 and the top `SECT_BITS` address bits, read as a number, are at least `cfg_sect`. In that case W = `cfg_wait_hi`; otherwise W = `cfg_wait_lo` (each field is 2 bits, values 0 to 3).
- R4: While enabled, the first cycle of every access has `ctl_out`={wr_n,rd_n,ale}=3'b111, `ad_out`=`req_addr[7:0]` and `ad_oe` all ones. In every later cycle of the same access, ale is 0.
- R5: Strobe cycles drive `ctl_out`=3'b100 for an external read and 3'b010 for an external write. Internal accesses and idle cycles never assert a strobe, and the two strobes are never low together.
- R6: During write strobes, `ad_out` carries the write byte with `ad_oe` all ones. During read strobes, `ad_oe` is all zeros, and `rd_data` equals `ad_in` in the accepting cycle.
- R7: High pin i is driven by the controller (`hi_oe[i]`=1, `hi_out[i]`=address bit 8+i) when enabled and i < min(`cfg_hi_bits`, 8). Otherwise pin i follows `port_hi_out[i]` and `port_hi_oe[i]`. The driven bits hold the address through the whole bus cycle.
- R8: With `cfg_en`=0, the `ad_*`, `hi_*` and `ctl_*` pins equal their `port_*` inputs, and every request is accepted in its first cycle, including addresses above `INT_TOP`.
- R9: While enabled and idle, `ctl_oe`=3'b111, `ctl_out`=3'b110 and `ad_oe`=0.
- R10: `ad_hold` is 1 exactly when the interface is enabled, `cfg_keep`=1 and the shared lines are not driven. The value on `ad_out` is then the last byte the controller drove.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Interface enable |
| cfg_keep | input | 1 | Bus keeper enable |
| cfg_sect | input | SECT_BITS | Upper-sector start, in units of the top address bits; 0 means a single sector |
| cfg_wait_lo | input | 2 | Wait count for the lower sector |
| cfg_wait_hi | input | 2 | Wait count for the upper sector |
| cfg_hi_bits | input | HBW | Number of high-address pins driven (clamped to AW-DW) |
| req_valid | input | 1 | CPU request valid |
| req_ready | output | 1 | Request accepted this cycle; low means stall |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write byte |
| rd_data | output | DW | Read byte, valid in the accepting cycle of an external read |
| ad_in | input | DW | Shared lines as seen from the pad |
| ad_out | output | DW | Shared lines output value |
| ad_oe | output | DW | Shared lines output enable |
| ad_hold | output | 1 | Keeper active on the shared lines |
| hi_out | output | AW-DW | High-address pin values |
| hi_oe | output | AW-DW | High-address pin enables |
| ctl_out | output | 3 | {wr_n, rd_n, ale} |
| ctl_oe | output | 3 | Control pin enables |
| port_ad_out | input | DW | Plain port value for the shared lines |
| port_ad_oe | input | DW | Plain port direction for the shared lines |
| port_hi_out | input | AW-DW | Plain port value for the high pins |
| port_hi_oe | input | AW-DW | Plain port direction for the high pins |
| port_ctl_out | input | 3 | Plain port value for the control pins |
| port_ctl_oe | input | 3 | Plain port direction for the control pins |

## Verification
The bench keeps AW=16, DW=8 and SECT_BITS=3, but lowers `INT_TOP` to 0x04FF. With that setting most random addresses fall in the external space, which makes every wait count and both sectors common. The internal/external edge sits at an address that is easy to hit directly. Because `cfg_hi_bits` is 4 bits wide, the random configurations include values above 8, which exercises the clamp on the high-pin width. With the 3-bit sector field, the directed cases can put the sector split on either side of a chosen address.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int unsigned XB_WAIT_W = 2;

  typedef enum logic {
    XB_IDLE   = 1'b0,
    XB_STROBE = 1'b1
  } xb_state_e;
endpackage

// File: rtl/xbus_decode.sv
module xbus_decode #(
  parameter int unsigned AW        = 16,
  parameter int unsigned INT_TOP   = 32'h10FF,
  parameter int unsigned SECT_BITS = 3,
  parameter int unsigned WAIT_W    = 2
) (
  input  logic [AW-1:0]        addr,
  input  logic                 cfg_en,
  input  logic [SECT_BITS-1:0] cfg_sect,
  input  logic [WAIT_W-1:0]    cfg_wait_lo,
  input  logic [WAIT_W-1:0]    cfg_wait_hi,
  output logic                 is_ext,
  output logic [WAIT_W-1:0]    wait_sel
);
  localparam logic [AW-1:0] TOP_L = AW'(INT_TOP);

  logic upper;

  always_comb begin
    is_ext   = cfg_en && (addr > TOP_L);
    upper    = (cfg_sect != '0) && (addr[AW-1 -: SECT_BITS] >= cfg_sect);
    wait_sel = upper ? cfg_wait_hi : cfg_wait_lo;
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int unsigned AW     = 16,
  parameter int unsigned DW     = 8,
  parameter int unsigned WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic              is_ext,
  input  logic [WAIT_W-1:0] wait_sel,
  output logic              req_ready,
  output logic              ale,
  output logic              rd_act,
  output logic              wr_act,
  output logic              drive_ad,
  output logic [DW-1:0]     ad_val,
  output logic [AW-1:0]     bus_addr,
  output logic              strobe_last
);
  xb_state_e         state;
  logic [WAIT_W-1:0] cnt;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     wdata_q;
  logic              we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= XB_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
    end else begin
      case (state)
        XB_IDLE: begin
          if (req_valid) begin
            addr_q <= req_addr;
            if (is_ext) begin
              state   <= XB_STROBE;
              cnt     <= wait_sel;
              we_q    <= req_we;
              wdata_q <= req_wdata;
            end
          end
        end
        XB_STROBE: begin
          if (cnt == '0) state <= XB_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= XB_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready   = 1'b1;
    ale         = 1'b0;
    rd_act      = 1'b0;
    wr_act      = 1'b0;
    drive_ad    = 1'b0;
    ad_val      = req_addr[DW-1:0];
    bus_addr    = addr_q;
    strobe_last = 1'b0;
    if (state == XB_IDLE) begin
      if (req_valid) begin
        ale       = 1'b1;
        drive_ad  = 1'b1;
        bus_addr  = req_addr;
        req_ready = !is_ext;
      end
    end else begin
      strobe_last = (cnt == '0);
      req_ready   = strobe_last;
      rd_act      = !we_q;
      wr_act      = we_q;
      drive_ad    = we_q;
      ad_val      = wdata_q;
    end
  end
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins #(
  parameter int unsigned DW  = 8,
  parameter int unsigned HIW = 8,
  parameter int unsigned HBW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_en,
  input  logic           cfg_keep,
  input  logic [HBW-1:0] cfg_hi_bits,
  input  logic           ale,
  input  logic           rd_act,
  input  logic           wr_act,
  input  logic           drive_ad,
  input  logic [DW-1:0]  ad_val,
  input  logic [HIW-1:0] bus_hi,
  input  logic [DW-1:0]  port_ad_out,
  input  logic [DW-1:0]  port_ad_oe,
  input  logic [HIW-1:0] port_hi_out,
  input  logic [HIW-1:0] port_hi_oe,
  input  logic [2:0]     port_ctl_out,
  input  logic [2:0]     port_ctl_oe,
  output logic [DW-1:0]  ad_out,
  output logic [DW-1:0]  ad_oe,
  output logic           ad_hold,
  output logic [HIW-1:0] hi_out,
  output logic [HIW-1:0] hi_oe,
  output logic [2:0]     ctl_out,
  output logic [2:0]     ctl_oe
);
  localparam logic [HBW-1:0] HIW_L = HBW'(HIW);

  logic [DW-1:0]  keep_q;
  logic [HBW-1:0] hi_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  keep_q <= '0;
    else if (cfg_en && drive_ad) keep_q <= ad_val;
  end

  assign hi_w = (cfg_hi_bits > HIW_L) ? HIW_L : cfg_hi_bits;

  for (genvar g = 0; g < HIW; g++) begin : g_hi
    logic own;
    assign own       = cfg_en && (HBW'(g) < hi_w);
    assign hi_out[g] = own ? bus_hi[g] : port_hi_out[g];
    assign hi_oe[g]  = own ? 1'b1      : port_hi_oe[g];
  end

  always_comb begin
    if (cfg_en) begin
      ad_out  = drive_ad ? ad_val : keep_q;
      ad_oe   = {DW{drive_ad}};
      ad_hold = cfg_keep && !drive_ad;
      ctl_out = {~wr_act, ~rd_act, ale};
      ctl_oe  = 3'b111;
    end else begin
      ad_out  = port_ad_out;
      ad_oe   = port_ad_oe;
      ad_hold = 1'b0;
      ctl_out = port_ctl_out;
      ctl_oe  = port_ctl_oe;
    end
  end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl #(
  parameter int unsigned AW        = 16,
  parameter int unsigned DW        = 8,
  parameter int unsigned INT_TOP   = 32'h10FF,
  parameter int unsigned SECT_BITS = 3,
  localparam int unsigned HIW      = AW - DW,
  localparam int unsigned HBW      = $clog2(HIW + 1),
  localparam int unsigned WAIT_W   = xbus_pkg::XB_WAIT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_en,
  input  logic                 cfg_keep,
  input  logic [SECT_BITS-1:0] cfg_sect,
  input  logic [WAIT_W-1:0]    cfg_wait_lo,
  input  logic [WAIT_W-1:0]    cfg_wait_hi,
  input  logic [HBW-1:0]       cfg_hi_bits,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_we,
  input  logic [AW-1:0]        req_addr,
  input  logic [DW-1:0]        req_wdata,
  output logic [DW-1:0]        rd_data,
  input  logic [DW-1:0]        ad_in,
  output logic [DW-1:0]        ad_out,
  output logic [DW-1:0]        ad_oe,
  output logic                 ad_hold,
  output logic [HIW-1:0]       hi_out,
  output logic [HIW-1:0]       hi_oe,
  output logic [2:0]           ctl_out,
  output logic [2:0]           ctl_oe,
  input  logic [DW-1:0]        port_ad_out,
  input  logic [DW-1:0]        port_ad_oe,
  input  logic [HIW-1:0]       port_hi_out,
  input  logic [HIW-1:0]       port_hi_oe,
  input  logic [2:0]           port_ctl_out,
  input  logic [2:0]           port_ctl_oe
);
  logic              is_ext;
  logic [WAIT_W-1:0] wait_sel;
  logic              ale, rd_act, wr_act, drive_ad, strobe_last;
  logic [DW-1:0]     ad_val;
  logic [AW-1:0]     bus_addr;
  logic [DW-1:0]     rd_hold;

  xbus_decode #(.AW(AW), .INT_TOP(INT_TOP), .SECT_BITS(SECT_BITS), .WAIT_W(WAIT_W)) u_decode (
    .addr(req_addr), .cfg_en(cfg_en), .cfg_sect(cfg_sect),
    .cfg_wait_lo(cfg_wait_lo), .cfg_wait_hi(cfg_wait_hi),
    .is_ext(is_ext), .wait_sel(wait_sel)
  );

  xbus_seq #(.AW(AW), .DW(DW), .WAIT_W(WAIT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .is_ext(is_ext), .wait_sel(wait_sel),
    .req_ready(req_ready), .ale(ale), .rd_act(rd_act), .wr_act(wr_act),
    .drive_ad(drive_ad), .ad_val(ad_val), .bus_addr(bus_addr), .strobe_last(strobe_last)
  );

  xbus_pins #(.DW(DW), .HIW(HIW), .HBW(HBW)) u_pins (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_keep(cfg_keep), .cfg_hi_bits(cfg_hi_bits),
    .ale(ale), .rd_act(rd_act), .wr_act(wr_act), .drive_ad(drive_ad), .ad_val(ad_val),
    .bus_hi(bus_addr[AW-1:DW]),
    .port_ad_out(port_ad_out), .port_ad_oe(port_ad_oe),
    .port_hi_out(port_hi_out), .port_hi_oe(port_hi_oe),
    .port_ctl_out(port_ctl_out), .port_ctl_oe(port_ctl_oe),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_hold(ad_hold),
    .hi_out(hi_out), .hi_oe(hi_oe), .ctl_out(ctl_out), .ctl_oe(ctl_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     rd_hold <= '0;
    else if (strobe_last && rd_act) rd_hold <= ad_in;
  end

  assign rd_data = (strobe_last && rd_act) ? ad_in : rd_hold;
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(
  parameter int unsigned AW      = 16,
  parameter int unsigned DW      = 8,
  parameter int unsigned INT_TOP = 32'h10FF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_en,
  input logic              req_valid,
  input logic              req_ready,
  input logic [AW-1:0]     req_addr,
  input logic [DW-1:0]     ad_out,
  input logic              ad_hold,
  input logic [AW-DW-1:0]  hi_out,
  input logic [2:0]        ctl_out
);
  localparam logic [AW-1:0] TOP_L = AW'(INT_TOP);

  logic [3:0] stall_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               stall_cnt <= '0;
    else if (req_valid && !req_ready) begin
      if (stall_cnt != 4'hF)                  stall_cnt <= stall_cnt + 1'b1;
    end else                                  stall_cnt <= '0;
  end

  // R1: an internal address with the latch pulse is accepted at once
  p_internal_now_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en && req_valid && ctl_out[0] && (req_addr <= TOP_L) |-> req_ready);

  // R2: no access is stalled for more than four cycles
  p_stall_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stall_cnt <= 4'd4);

  // R4: strobes are idle while the latch enable is high
  p_ale_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en && ctl_out[0] |-> (ctl_out[2:1] == 2'b11));

  // R5: read and write strobes never overlap
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |-> (ctl_out[2] || ctl_out[1]));

  // R7: high address stays put while a read strobe continues
  p_hi_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en && !ctl_out[1] |=> (ctl_out[1] || $stable(hi_out)));

  // R8: a disabled interface never stalls
  p_no_stall_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en && req_valid |-> req_ready);

  // R10: the keeper shows the last driven byte
  p_keep_value_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ad_hold && $past(cfg_en) |-> $stable(ad_out));
endmodule

bind xbus_ctrl xbus_ctrl_chk #(.AW(AW), .DW(DW), .INT_TOP(INT_TOP)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .ad_out(ad_out), .ad_hold(ad_hold), .hi_out(hi_out), .ctl_out(ctl_out)
);

// File: tb/xbus_ctrl_bench.sv
module xbus_ctrl_bench;
  localparam int unsigned AW  = 16;
  localparam int unsigned DW  = 8;
  localparam int unsigned TOP = 32'h04FF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       cfg_en = 1'b1, cfg_keep = 1'b1;
  logic [2:0] cfg_sect = '0;
  logic [1:0] cfg_wait_lo = '0, cfg_wait_hi = '0;
  logic [3:0] cfg_hi_bits = 4'd8;
  logic       req_valid = 1'b0, req_we = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       req_ready, ad_hold;
  logic [7:0] rd_data, ad_in, ad_out, ad_oe, hi_out, hi_oe;
  logic [2:0] ctl_out, ctl_oe;
  logic [7:0] port_ad_out = 8'h5A, port_ad_oe = 8'h0F, port_hi_out = 8'hC3, port_hi_oe = 8'h99;
  logic [2:0] port_ctl_out = 3'b011, port_ctl_oe = 3'b101;
  logic [7:0] dev_val = '0;
  logic [7:0] last_drv = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit ended = 1'b0;

  always_comb ad_in = (ctl_out[1] == 1'b0) ? dev_val : 8'hEE;

  xbus_ctrl #(.AW(AW), .DW(DW), .INT_TOP(TOP), .SECT_BITS(3)) u_xbus_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_keep(cfg_keep), .cfg_sect(cfg_sect),
    .cfg_wait_lo(cfg_wait_lo), .cfg_wait_hi(cfg_wait_hi), .cfg_hi_bits(cfg_hi_bits),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_data(rd_data), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .ad_hold(ad_hold), .hi_out(hi_out), .hi_oe(hi_oe), .ctl_out(ctl_out), .ctl_oe(ctl_oe),
    .port_ad_out(port_ad_out), .port_ad_oe(port_ad_oe), .port_hi_out(port_hi_out),
    .port_hi_oe(port_hi_oe), .port_ctl_out(port_ctl_out), .port_ctl_oe(port_ctl_oe)
  );

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finish_run();
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_wait(logic [15:0] a);
    if (cfg_sect != 3'd0 && a[15:13] >= cfg_sect) return int'(cfg_wait_hi);
    return int'(cfg_wait_lo);
  endfunction

  function automatic logic [7:0] own_mask();
    int w = (cfg_hi_bits > 4'd8) ? 8 : int'(cfg_hi_bits);
    if (!cfg_en) return 8'h00;
    return 8'((32'd1 << w) - 1);
  endfunction

  task automatic run_access(logic [15:0] a, bit we, logic [7:0] wd);
    bit ext = cfg_en && (32'(a) > TOP);
    int w = ext ? exp_wait(a) : 0;
    logic [7:0] m = own_mask();
    bit got = 1'b0;
    dev_val = a[7:0] ^ a[15:8] ^ 8'h3C;
    @(negedge clk);
    req_addr = a; req_we = we; req_wdata = wd; req_valid = 1'b1;
    for (int cyc = 0; cyc < 8; cyc++) begin
      #2;
      chk(hi_out == ((a[15:8] & m) | (port_hi_out & ~m)), "R7 hi_out", hi_out, (a[15:8] & m) | (port_hi_out & ~m));
      chk(hi_oe == (m | (port_hi_oe & ~m)), "R7 hi_oe", hi_oe, m | (port_hi_oe & ~m));
      if (!cfg_en) begin
        chk(ctl_out == port_ctl_out && ctl_oe == port_ctl_oe, "R8 ctl", ctl_out, port_ctl_out);
        chk(ad_out == port_ad_out && ad_oe == port_ad_oe, "R8 ad", ad_out, port_ad_out);
      end else if (cyc == 0) begin
        chk(ctl_out == 3'b111, "R4 ctl", ctl_out, 3'b111);
        chk(ad_out == a[7:0] && ad_oe == 8'hFF, "R4 ad", ad_out, a[7:0]);
      end else begin
        chk(ctl_out == (we ? 3'b010 : 3'b100), "R5 strobe", ctl_out, we ? 3'b010 : 3'b100);
        if (we) chk(ad_out == wd && ad_oe == 8'hFF, "R6 wdata", ad_out, wd);
        else    chk(ad_oe == 8'h00, "R6 read oe", ad_oe, 0);
      end
      if (req_ready) begin
        got = 1'b1;
        chk(cyc == w + (ext ? 1 : 0), ext ? "R2 R3 stall" : "R1 accept", cyc, w + (ext ? 1 : 0));
        if (ext && !we) chk(rd_data == dev_val, "R6 rdata", rd_data, dev_val);
        if (cfg_en) last_drv = (ext && we) ? wd : a[7:0];
      end
      @(negedge clk);
      if (got) break;
    end
    if (!got) chk(1'b0, "R2 never ready", 0, 1);
    req_valid = 1'b0;
  endtask

  task automatic chk_idle();
    #2;
    if (cfg_en) begin
      chk(ad_hold == cfg_keep, "R10 hold", ad_hold, cfg_keep);
      if (cfg_keep) chk(ad_out == last_drv, "R10 keep", ad_out, last_drv);
      chk(ctl_out == 3'b110 && ctl_oe == 3'b111 && ad_oe == 8'h00, "R9 idle", ctl_out, 3'b110);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    #2;
    chk(req_ready == 1'b1, "R9 reset ready", req_ready, 1);
    chk(ctl_out == 3'b110 && ctl_oe == 3'b111, "R9 reset ctl", ctl_out, 3'b110);
    chk(ad_hold == 1'b1 && ad_out == 8'h00 && ad_oe == 8'h00, "R10 reset keep", ad_out, 0);

    // R1 boundary of the internal region
    cfg_wait_lo = 2'd2;
    run_access(16'h04FF, 1'b0, 8'h00); chk_idle();
    run_access(16'h0500, 1'b0, 8'h00); chk_idle();
    run_access(16'h0000, 1'b1, 8'h11); chk_idle();

    // R2 every wait count
    for (int k = 0; k < 4; k++) begin
      cfg_wait_lo = 2'(k);
      run_access(16'h2345, 1'b1, 8'(8'hA0 + k)); chk_idle();
      run_access(16'h2346, 1'b0, 8'h00); chk_idle();
    end

    // R3 sector split on both sides
    cfg_sect = 3'd3; cfg_wait_lo = 2'd1; cfg_wait_hi = 2'd3;
    run_access(16'h5FFF, 1'b0, 8'h00); chk_idle();
    run_access(16'h6000, 1'b0, 8'h00); chk_idle();
    cfg_sect = 3'd0;
    run_access(16'hE000, 1'b1, 8'h77); chk_idle();

    // R7 high width: none, partial, clamp
    cfg_hi_bits = 4'd0;  run_access(16'hBEEF, 1'b0, 8'h00); chk_idle();
    cfg_hi_bits = 4'd3;  run_access(16'h9ABC, 1'b1, 8'h42); chk_idle();
    cfg_hi_bits = 4'd12; run_access(16'hFFFF, 1'b0, 8'h00); chk_idle();

    // R10 keeper off
    cfg_keep = 1'b0; run_access(16'h1234, 1'b1, 8'h99); chk_idle();
    cfg_keep = 1'b1;

    // R8 disabled interface
    cfg_en = 1'b0; cfg_wait_lo = 2'd3;
    run_access(16'h8000, 1'b0, 8'h00);
    run_access(16'h0100, 1'b1, 8'h55);
    cfg_en = 1'b1;

    // random traffic
    for (int i = 0; i < 400; i++) begin
      if (i % 25 == 0) begin
        cfg_en       = ($urandom % 8) != 0;
        cfg_keep     = 1'($urandom);
        cfg_sect     = 3'($urandom);
        cfg_wait_lo  = 2'($urandom);
        cfg_wait_hi  = 2'($urandom);
        cfg_hi_bits  = 4'($urandom);
        port_ad_out  = 8'($urandom);
        port_ad_oe   = 8'($urandom);
        port_hi_out  = 8'($urandom);
        port_hi_oe   = 8'($urandom);
        port_ctl_out = 3'($urandom);
        port_ctl_oe  = 3'($urandom);
      end
      run_access(16'($urandom), 1'($urandom), 8'($urandom));
      chk_idle();
    end
    finish_run();
  end
endmodule